// File: doc/BRIEF.md
# Lock Qualification Timer with Output Gating

This block turns the raw, possibly chattering lock flag of a digital lock detector into a clean qualified-lock signal. While the raw flag stays true, an internal counter advances by one step per clock. Any single clock in which the raw flag is false clears the counter at once. The qualified flag rises only when the counter reaches an upper trip level, which means the raw flag has been true for long enough without a break. While the flag is high, it is released when the counter falls below a lower trip level. The two trip levels are runtime inputs, so the qualifying interval can be set without a rebuild.

The qualified flag also gates a vector of per-output clock-enable requests. An output whose gate bit is set is enabled only while the qualified flag is high, so it is held off until the loop has settled. An output whose gate bit is clear follows its request directly. A separate enable input turns the qualifier off; while it is off, the qualified flag stays low and the counter stays at zero.

Top module: `lock_qualifier`

## Requirements
- R1: While reset is asserted, the counter is zero and `lock_ok` is low, so every output whose `gate_mask` bit is 1 drives 0 on `en_out`.
- R2: When `qual_en` and `raw_lock` are both sampled high, the counter advances by one at each rising edge. When `lock_ok` is low, it rises at the same edge at which the counter reaches `trip_hi`, that is, on the `trip_hi`-th consecutive high sample.
- R3: If `raw_lock` is sampled low at a rising edge, the counter is zero after that edge, and a later high run starts counting again from zero.
- R4: When the counter reaches its all-ones value (2^CNT_W-1), it holds there instead of wrapping to zero, so a held lock is not lost after a long high run.
- R5: The trip levels have hysteresis. While `lock_ok` is high, it stays high as long as the updated counter is at or above `trip_lo`, even if `trip_hi` is now above the counter. It falls at the edge at which the counter drops below `trip_lo`. The inputs must satisfy 1 <= `trip_lo` <= `trip_hi`.
- R6: When `qual_en` is sampled low, the counter is cleared and `lock_ok` is low after that edge, whatever the state of `raw_lock`.
- R7: For every output i with `gate_mask[i]` = 1, `en_out[i]` equals `en_req[i]` AND `lock_ok`. This path is combinational.
- R8: For every output i with `gate_mask[i]` = 0, `en_out[i]` equals `en_req[i]` in any lock state. This path is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| qual_en | input | 1 | Qualifier enable |
| raw_lock | input | 1 | Raw lock flag from the digital lock detector |
| trip_hi | input | CNT_W | Upper trip level; reaching it asserts lock |
| trip_lo | input | CNT_W | Lower trip level; dropping below it releases lock |
| gate_mask | input | N_OUT | 1 = the output waits for qualified lock |
| en_req | input | N_OUT | Per-output enable requests |
| lock_ok | output | 1 | Qualified lock flag |
| en_out | output | N_OUT | Gated per-output enables |

## Verification
On every cycle, the assertions check how the counter evolves: it steps by one, it clears on a low raw sample or on disable, and it saturates at all-ones. They also check that each edge of `lock_ok` happens only when the counter meets the trip level that applies at that moment. Some behaviour needs a sequence of stimulus to show and is left to the bench scenarios: the exact cycle at which lock appears after a broken run, hysteresis shown by moving the trip levels while locked, and lock being held through a long saturated run. The combination of gate mask and request patterns is also covered by the bench.

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int CNT_W = 16,
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual_en,
  input  logic             raw_lock,
  input  logic [CNT_W-1:0] trip_hi,
  input  logic [CNT_W-1:0] trip_lo,
  input  logic [N_OUT-1:0] gate_mask,
  input  logic [N_OUT-1:0] en_req,
  output logic             lock_ok,
  output logic [N_OUT-1:0] en_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_nx;
  logic             lock_nx;

  assign acc_nx = (!qual_en || !raw_lock) ? '0 :
                  (acc_q == CNT_MAX)      ? acc_q :
                                            acc_q + CNT_W'(1);

  always_comb begin
    if (!qual_en)     lock_nx = 1'b0;
    else if (lock_ok) lock_nx = (acc_nx >= trip_lo);
    else              lock_nx = (acc_nx >= trip_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      lock_ok <= 1'b0;
    end else begin
      acc_q   <= acc_nx;
      lock_ok <= lock_nx;
    end
  end

  assign en_out = en_req & (~gate_mask | {N_OUT{lock_ok}});

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_en && raw_lock && acc_q != CNT_MAX) |=> (acc_q == $past(acc_q) + CNT_W'(1)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_lock |=> (acc_q == '0));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_en && raw_lock && acc_q == CNT_MAX) |=> (acc_q == CNT_MAX));

  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_ok) |-> (acc_q >= $past(trip_hi)));

  p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_ok) |-> (!$past(qual_en) || acc_q < $past(trip_lo)));

  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_en |=> (!lock_ok && acc_q == '0));

  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |-> ((en_out & gate_mask) == '0));
endmodule

// File: tb/lock_qualifier_tb.sv
module lock_qualifier_tb_top;
  localparam int CW = 6;
  localparam int NO = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          qual_en = 1'b0;
  logic          raw_lock = 1'b0;
  logic [CW-1:0] trip_hi = CW'(5);
  logic [CW-1:0] trip_lo = CW'(3);
  logic [NO-1:0] gate_mask = '1;
  logic [NO-1:0] en_req = '1;
  logic          lock_ok;
  logic [NO-1:0] en_out;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lock_qualifier #(.CNT_W(CW), .N_OUT(NO)) dut_i (
    .clk(clk), .rst_n(rst_n), .qual_en(qual_en), .raw_lock(raw_lock),
    .trip_hi(trip_hi), .trip_lo(trip_lo), .gate_mask(gate_mask),
    .en_req(en_req), .lock_ok(lock_ok), .en_out(en_out));

  // {cycles[7:0], en, raw, mask[3:0], req[3:0], exp_lock, exp_out[3:0]}, trip 5/3
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {8'd4, 1'b1, 1'b1, 4'b1100, 4'b1111, 1'b0, 4'b0011},
    {8'd1, 1'b1, 1'b1, 4'b1100, 4'b1111, 1'b1, 4'b1111},
    {8'd1, 1'b1, 1'b0, 4'b1100, 4'b1111, 1'b0, 4'b0011},
    {8'd3, 1'b1, 1'b1, 4'b1100, 4'b1010, 1'b0, 4'b0010},
    {8'd2, 1'b1, 1'b1, 4'b1100, 4'b1010, 1'b1, 4'b1010},
    {8'd1, 1'b0, 1'b1, 4'b1100, 4'b1111, 1'b0, 4'b0011},
    {8'd5, 1'b1, 1'b1, 4'b0000, 4'b0101, 1'b1, 4'b0101},
    {8'd1, 1'b1, 1'b1, 4'b1111, 4'b1111, 1'b1, 4'b1111}
  };

  task automatic check(input string req, input logic exp_lock, input logic [NO-1:0] exp_out);
    n_run++;
    if (lock_ok !== exp_lock || en_out !== exp_out) begin
      n_bad++;
      $display("FAIL %s: lock_ok=%b en_out=%b expected lock_ok=%b en_out=%b",
               req, lock_ok, en_out, exp_lock, exp_out);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart();
    @(negedge clk);
    qual_en = 1'b0;
    run(1);
    @(negedge clk);
    qual_en = 1'b1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    gate_mask = 4'b1111; en_req = 4'b1111; #1;
    check("R1 reset gated", 1'b0, 4'b0000);
    gate_mask = 4'b0101; #1;
    check("R1 R8 reset pass", 1'b0, 4'b1010);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      qual_en   = VEC[i][14];
      raw_lock  = VEC[i][13];
      gate_mask = VEC[i][12:9];
      en_req    = VEC[i][8:5];
      run(int'(VEC[i][22:15]));
      check($sformatf("R2 R3 R6 R7 R8 vector %0d", i), VEC[i][4], VEC[i][3:0]);
    end

    // R3: broken run restarts from zero
    gate_mask = 4'b1111; en_req = 4'b1111;
    restart();
    raw_lock = 1'b1; run(4);
    @(negedge clk); raw_lock = 1'b0; run(1);
    @(negedge clk); raw_lock = 1'b1; run(4);
    check("R3 restart after glitch", 1'b0, 4'b0000);
    run(1);
    check("R2 lock at trip_hi", 1'b1, 4'b1111);

    // R5: hysteresis with runtime trip levels
    restart();
    trip_hi = CW'(5); trip_lo = CW'(3); raw_lock = 1'b1;
    run(6);
    check("R5 locked", 1'b1, 4'b1111);
    @(negedge clk); trip_hi = CW'(20); run(1);
    check("R5 held above lower level", 1'b1, 4'b1111);
    @(negedge clk); trip_lo = CW'(10); run(1);
    check("R5 release below lower level", 1'b0, 4'b0000);
    run(11);
    check("R5 upper level needed again", 1'b0, 4'b0000);
    run(1);
    check("R5 relock at upper level", 1'b1, 4'b1111);

    // R4: saturation at 63
    restart();
    trip_hi = CW'(63); trip_lo = CW'(10); raw_lock = 1'b1;
    run(62);
    check("R4 not yet at max", 1'b0, 4'b0000);
    run(1);
    check("R4 lock at max", 1'b1, 4'b1111);
    run(40);
    check("R4 no wrap", 1'b1, 4'b1111);

    // R6: disable with raw high
    @(negedge clk); qual_en = 1'b0; run(1);
    check("R6 disable", 1'b0, 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule